// File: doc/BRIEF.md
# Multi-Header Error Log Queue

This block holds the uncorrectable-error header log of one device. A record carries a one-hot status, two flags (header valid, prefix present) and four header and four prefix dwords. The first accepted record is loaded into the live log registers. A first-error pointer names the status bit that the live log describes. While that pointed status bit is still set, software has not yet serviced the live record. If multi-header recording is active during that time, later records wait in a small FIFO instead of overwriting the live log.

Software services the live record by writing ones to the uncorrectable status register. After each such write the block looks at the bit under the pointer. If that bit has been cleared and records are waiting, the oldest waiting record moves into the live log. If nothing is waiting, or recording is off, the live log is wiped. When the FIFO is full, a new record is dropped and the block raises a one-cycle request for a header-log-overflow correctable error.

Records arrive over a valid/ready stream. `rec_ready` is low in any cycle in which `clr_valid` is high, and a producer must hold its record until it sees ready. Status writes have no handshake and always take effect in their cycle.

Top module: `errlog_queue`

## Requirements
- R1: A record whose status does not have exactly one bit set is accepted by the handshake but changes nothing: status, live log, pointer and FIFO all keep their values.
- R2: Reset clears the pointer, the status register, both logs, the prefix-present bit and the overflow request, and it empties the FIFO (`q_count` = 0).
- R3: An accepted valid record is queued only when recording is active and `unc_status[first_ptr]` is 1 before the record. Otherwise it is loaded into the live log, and `first_ptr` becomes the index of its set bit. In both cases its status bit is ORed into `unc_status`.
- R4: An accepted record that would be queued while `q_count` equals DEPTH is dropped, its status bit is still ORed in, and `ovf_err` is 1 for exactly the next cycle.
- R5: On a live load with the header-valid flag set, header log dword i (bits 32i+31..32i) holds input dword i with its byte order reversed: input bits 31..24 go to bits 7..0. With the flag clear, the header log becomes zero.
- R6: A live load stores the prefix dwords in the same byte-reversed order and sets `pfx_present` only when the record's prefix flag and `pfx_supported` are both 1. Otherwise the prefix log is zero and `pfx_present` is 0.
- R7: If a status write leaves `unc_status[first_ptr]` at 0 while recording is active and the FIFO is not empty, the statuses of all queued records are ORed back into the register. The oldest record (FIFO order) is then loaded live, and `q_count` drops by one.
- R8: If a status write leaves the pointed bit at 0 while recording is inactive or the FIFO is empty, the pointer, `pfx_present`, the header log and the prefix log all become 0.
- R9: If the pointed bit is still 1 after a status write, active recording ORs all queued statuses back into the register. Inactive recording empties the FIFO.
- R10: `multi_capable` is 1 exactly when DEPTH > 0. `multi_active` equals `multi_en` AND `multi_capable`.
- R11: `rec_ready` is 0 whenever `clr_valid` is 1. A record offered in such a cycle has no effect.
- R12: Status bits are set only by accepted records (or re-ORed queue statuses) and are cleared only by a write of 1 to that bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rec_valid | input | 1 | Record offered |
| rec_ready | output | 1 | Record accepted this cycle when valid |
| rec_status | input | STAT_W | One-hot uncorrectable status of the record |
| rec_hdr_valid | input | 1 | Header dwords are meaningful |
| rec_pfx_flag | input | 1 | Record carries prefix dwords |
| rec_hdr | input | 128 | Four header dwords, dword i at bits 32i+31..32i |
| rec_pfx | input | 128 | Four prefix dwords, same layout |
| clr_valid | input | 1 | Write-one-to-clear strobe on the status register |
| clr_mask | input | STAT_W | Bits to clear |
| multi_en | input | 1 | Multi-header recording requested |
| pfx_supported | input | 1 | Device supports end-to-end prefixes |
| multi_capable | output | 1 | Queue exists (DEPTH > 0) |
| multi_active | output | 1 | Recording enable in effect |
| first_ptr | output | log2(STAT_W) | First-error pointer |
| hdr_log | output | 128 | Live header log |
| pfx_log | output | 128 | Live prefix log |
| pfx_present | output | 1 | Live prefix log is valid |
| unc_status | output | STAT_W | Accumulated uncorrectable status |
| q_count | output | CNT_W | Queue occupancy |
| ovf_err | output | 1 | One-cycle header-log-overflow request |

## Verification
The bench builds one instance with STAT_W = 32 and DEPTH = 4. A depth of four can be filled in a few records, so overflow, re-ORing after partial clears, ordered popping and flushing are all reached in short sequences. A second instance with DEPTH = 0 shows that the capable bit and the enable read as 0 and that every record then goes straight to the live log. The random phase confines status bits to the low eight, so records often land on the bit under the pointer and status writes often clear it.

// File: rtl/errlog_pkg.sv
package errlog_pkg;
  localparam int NDW     = 4;
  localparam int DWORD_W = 32;
  localparam int LOG_W   = NDW * DWORD_W;

  typedef struct packed {
    logic                           hdr_valid;
    logic                           pfx_flag;
    logic [NDW-1:0][DWORD_W-1:0]    hdr;
    logic [NDW-1:0][DWORD_W-1:0]    pfx;
  } rec_payload_t;

  function automatic logic [DWORD_W-1:0] byte_rev(input logic [DWORD_W-1:0] d);
    logic [DWORD_W-1:0] r;
    for (int b = 0; b < DWORD_W / 8; b++)
      r[8*b +: 8] = d[DWORD_W - 8*(b+1) +: 8];
    return r;
  endfunction
endpackage

// File: rtl/errlog_onehot_idx.sv
module errlog_onehot_idx #(
  parameter int W = 32,
  localparam int IW = (W < 2) ? 1 : $clog2(W)
) (
  input  logic [W-1:0]  vec,
  output logic          is_onehot,
  output logic [IW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = 0; i < W; i++)
      if (vec[i]) idx = idx | IW'(i);
  end

  assign is_onehot = (vec != '0) && ((vec & (vec - W'(1))) == '0);
endmodule

// File: rtl/errlog_fifo.sv
module errlog_fifo #(
  parameter int DEPTH = 4,
  parameter int SW    = 32,
  parameter int PW    = 258,
  localparam int CNT_W = (DEPTH < 1) ? 1 : $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic             flush,
  input  logic [SW-1:0]    din_st,
  input  logic [PW-1:0]    din_pl,
  output logic [SW-1:0]    head_st,
  output logic [PW-1:0]    head_pl,
  output logic [SW-1:0]    st_or,
  output logic [CNT_W-1:0] count,
  output logic             empty,
  output logic             full
);
  generate
    if (DEPTH == 0) begin : g_none
      logic unused_inputs;
      assign unused_inputs = ^{clk, rst_n, push, pop, flush, din_st, din_pl};
      assign head_st = '0;
      assign head_pl = '0;
      assign st_or   = '0;
      assign count   = '0;
      assign empty   = 1'b1;
      assign full    = 1'b1;
    end else begin : g_queue
      logic [SW-1:0]    st_q [DEPTH];
      logic [PW-1:0]    pl_q [DEPTH];
      logic [CNT_W-1:0] cnt_q;

      always_ff @(posedge clk) begin
        if (!rst_n)     cnt_q <= '0;
        else if (flush) cnt_q <= '0;
        else if (push)  cnt_q <= cnt_q + CNT_W'(1);
        else if (pop)   cnt_q <= cnt_q - CNT_W'(1);
      end

      // slot 0 is the oldest entry; a pop shifts every slot down by one
      for (genvar k = 0; k < DEPTH; k++) begin : g_slot
        always_ff @(posedge clk) begin
          if (pop) begin
            if (k < DEPTH - 1) begin
              st_q[k] <= st_q[(k < DEPTH - 1) ? k + 1 : k];
              pl_q[k] <= pl_q[(k < DEPTH - 1) ? k + 1 : k];
            end
          end else if (push && cnt_q == CNT_W'(k)) begin
            st_q[k] <= din_st;
            pl_q[k] <= din_pl;
          end
        end
      end

      always_comb begin
        st_or = '0;
        for (int k = 0; k < DEPTH; k++)
          if (CNT_W'(k) < cnt_q) st_or = st_or | st_q[k];
      end

      assign head_st = st_q[0];
      assign head_pl = pl_q[0];
      assign count   = cnt_q;
      assign empty   = (cnt_q == '0);
      assign full    = (cnt_q == CNT_W'(DEPTH));

      // R4
      push_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full |=> (cnt_q <= CNT_W'(DEPTH)));
      // R7
      pop_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && !flush) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
    end
  endgenerate
endmodule

// File: rtl/errlog_live.sv
module errlog_live
  import errlog_pkg::*;
#(
  parameter int IW = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         wipe,
  input  logic [IW-1:0] ld_idx,
  input  rec_payload_t ld_pl,
  input  logic         pfx_supported,
  output logic [IW-1:0] ptr,
  output logic [LOG_W-1:0] hdr_log,
  output logic [LOG_W-1:0] pfx_log,
  output logic         pfx_present
);
  logic [LOG_W-1:0] hdr_rev, pfx_rev;

  for (genvar i = 0; i < NDW; i++) begin : g_dw
    assign hdr_rev[DWORD_W*i +: DWORD_W] = byte_rev(ld_pl.hdr[i]);
    assign pfx_rev[DWORD_W*i +: DWORD_W] = byte_rev(ld_pl.pfx[i]);
  end

  logic keep_pfx;
  assign keep_pfx = ld_pl.pfx_flag && pfx_supported;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr <= '0; hdr_log <= '0; pfx_log <= '0; pfx_present <= 1'b0;
    end else if (load) begin
      ptr         <= ld_idx;
      hdr_log     <= ld_pl.hdr_valid ? hdr_rev : '0;
      pfx_log     <= keep_pfx ? pfx_rev : '0;
      pfx_present <= keep_pfx;
    end else if (wipe) begin
      ptr <= '0; hdr_log <= '0; pfx_log <= '0; pfx_present <= 1'b0;
    end
  end

  // R6
  prefix_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pfx_present |-> (pfx_log == '0));
  // R8
  wipe_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wipe && !load) |=> (ptr == '0 && !pfx_present && hdr_log == '0));
endmodule

// File: rtl/errlog_queue.sv
module errlog_queue
  import errlog_pkg::*;
#(
  parameter int STAT_W = 32,
  parameter int DEPTH  = 4,
  localparam int IW    = (STAT_W < 2) ? 1 : $clog2(STAT_W),
  localparam int CNT_W = (DEPTH < 1) ? 1 : $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rec_valid,
  output logic              rec_ready,
  input  logic [STAT_W-1:0] rec_status,
  input  logic              rec_hdr_valid,
  input  logic              rec_pfx_flag,
  input  logic [LOG_W-1:0]  rec_hdr,
  input  logic [LOG_W-1:0]  rec_pfx,
  input  logic              clr_valid,
  input  logic [STAT_W-1:0] clr_mask,
  input  logic              multi_en,
  input  logic              pfx_supported,
  output logic              multi_capable,
  output logic              multi_active,
  output logic [IW-1:0]     first_ptr,
  output logic [LOG_W-1:0]  hdr_log,
  output logic [LOG_W-1:0]  pfx_log,
  output logic              pfx_present,
  output logic [STAT_W-1:0] unc_status,
  output logic [CNT_W-1:0]  q_count,
  output logic              ovf_err
);
  localparam int  PW      = $bits(rec_payload_t);
  localparam bit  CAPABLE = (DEPTH > 0);

  rec_payload_t      rec_pl, head_pl, ld_pl;
  logic [PW-1:0]     head_vec;
  logic [STAT_W-1:0] head_st, q_or, st_after, st_nxt;
  logic              rec_ok, head_ok_unused, q_empty, q_full;
  logic [IW-1:0]     rec_idx, head_idx, ld_idx;
  logic              act, cur_bit, bit_after, rec_fire;
  logic              push, pop, flush, ld, ld_from_q, wipe, ovf;

  always_comb begin
    rec_pl.hdr_valid = rec_hdr_valid;
    rec_pl.pfx_flag  = rec_pfx_flag;
    rec_pl.hdr       = rec_hdr;
    rec_pl.pfx       = rec_pfx;
  end
  assign head_pl = head_vec;

  errlog_onehot_idx #(.W(STAT_W)) u_rec_idx (
    .vec(rec_status), .is_onehot(rec_ok), .idx(rec_idx));
  errlog_onehot_idx #(.W(STAT_W)) u_head_idx (
    .vec(head_st), .is_onehot(head_ok_unused), .idx(head_idx));

  errlog_fifo #(.DEPTH(DEPTH), .SW(STAT_W), .PW(PW)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop), .flush(flush),
    .din_st(rec_status), .din_pl(rec_pl), .head_st(head_st), .head_pl(head_vec),
    .st_or(q_or), .count(q_count), .empty(q_empty), .full(q_full));

  assign multi_capable = CAPABLE;
  assign act           = multi_en && CAPABLE;
  assign multi_active  = act;
  assign rec_ready     = !clr_valid;
  assign rec_fire      = rec_valid && !clr_valid && rec_ok;
  assign cur_bit       = unc_status[first_ptr];
  assign st_after      = unc_status & ~clr_mask;
  assign bit_after     = st_after[first_ptr];

  always_comb begin
    st_nxt = unc_status; push = 1'b0; pop = 1'b0; flush = 1'b0;
    ld = 1'b0; ld_from_q = 1'b0; wipe = 1'b0; ovf = 1'b0;
    if (rec_fire) begin
      st_nxt = unc_status | rec_status;
      if (act && cur_bit) begin
        if (q_full) ovf  = 1'b1;
        else        push = 1'b1;
      end else begin
        ld = 1'b1;
      end
    end else if (clr_valid) begin
      st_nxt = st_after;
      if (!bit_after) begin
        if (act && !q_empty) begin
          st_nxt = st_after | q_or;
          pop = 1'b1; ld = 1'b1; ld_from_q = 1'b1;
        end else begin
          wipe = 1'b1;
        end
      end else if (act) begin
        st_nxt = st_after | q_or;
      end else begin
        flush = 1'b1;
      end
    end
  end

  assign ld_idx = ld_from_q ? head_idx : rec_idx;
  assign ld_pl  = ld_from_q ? head_pl  : rec_pl;

  errlog_live #(.IW(IW)) u_live (
    .clk(clk), .rst_n(rst_n), .load(ld), .wipe(wipe), .ld_idx(ld_idx),
    .ld_pl(ld_pl), .pfx_supported(pfx_supported), .ptr(first_ptr),
    .hdr_log(hdr_log), .pfx_log(pfx_log), .pfx_present(pfx_present));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      unc_status <= '0;
      ovf_err    <= 1'b0;
    end else begin
      unc_status <= st_nxt;
      ovf_err    <= ovf;
    end
  end

  // R12
  status_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_valid |=> ((unc_status & $past(unc_status)) == $past(unc_status)));
  // R4
  ovf_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_err |-> ($past(q_full) && $past(rec_valid)));
  // R1
  onehot_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid && !rec_ok && !clr_valid) |=> (unc_status == $past(unc_status)));
  // R9
  flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_valid && bit_after && !act) |=> (q_count == '0));
endmodule

// File: tb/tb_errlog_queue.sv
`timescale 1ns/1ps
module tb_errlog_queue;
  localparam int DEPTH = 4;
  logic clk = 1'b0, rst_n = 1'b0;
  logic rec_valid = 1'b0, rec_hdr_valid = 1'b0, rec_pfx_flag = 1'b0;
  logic [31:0] rec_status = '0, clr_mask = '0;
  logic [127:0] rec_hdr = '0, rec_pfx = '0;
  logic clr_valid = 1'b0, multi_en = 1'b0, pfx_supported = 1'b0;
  logic rec_ready, multi_capable, multi_active, pfx_present, ovf_err;
  logic [4:0] first_ptr;
  logic [127:0] hdr_log, pfx_log;
  logic [31:0] unc_status;
  logic [2:0] q_count;
  logic z_ready, z_cap, z_act, z_pp, z_ovf, z_cnt;
  logic [4:0] z_ptr;
  logic [127:0] z_hdr, z_pfx;
  logic [31:0] z_st;

  always #4 clk = ~clk;

  errlog_queue #(.STAT_W(32), .DEPTH(DEPTH)) dut (
    .clk, .rst_n, .rec_valid, .rec_ready, .rec_status, .rec_hdr_valid,
    .rec_pfx_flag, .rec_hdr, .rec_pfx, .clr_valid, .clr_mask, .multi_en,
    .pfx_supported, .multi_capable, .multi_active, .first_ptr, .hdr_log,
    .pfx_log, .pfx_present, .unc_status, .q_count, .ovf_err);

  errlog_queue #(.STAT_W(32), .DEPTH(0)) dut0 (
    .clk, .rst_n, .rec_valid, .rec_ready(z_ready), .rec_status, .rec_hdr_valid,
    .rec_pfx_flag, .rec_hdr, .rec_pfx, .clr_valid, .clr_mask, .multi_en,
    .pfx_supported, .multi_capable(z_cap), .multi_active(z_act),
    .first_ptr(z_ptr), .hdr_log(z_hdr), .pfx_log(z_pfx), .pfx_present(z_pp),
    .unc_status(z_st), .q_count(z_cnt), .ovf_err(z_ovf));

  int checks = 0, errors = 0;

  // bench model
  logic [31:0] m_st; logic [4:0] m_ptr; logic [127:0] m_hdr, m_pfx;
  logic m_pp, m_ovf; int m_cnt;
  logic [31:0] q_st[DEPTH]; logic q_hv[DEPTH], q_pf[DEPTH];
  logic [127:0] q_hdr[DEPTH], q_pfx[DEPTH];

  function automatic logic [127:0] swap4(input logic [127:0] d);
    logic [127:0] r;
    for (int i = 0; i < 4; i++)
      for (int b = 0; b < 4; b++)
        r[32*i + 8*b +: 8] = d[32*i + 8*(3-b) +: 8];
    return r;
  endfunction

  function automatic logic [4:0] bit_idx(input logic [31:0] s);
    logic [4:0] r = '0;
    for (int i = 0; i < 32; i++) if (s[i]) r = 5'(i);
    return r;
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic m_load(input logic [31:0] st, input logic hv, input logic pf,
                        input logic [127:0] h, input logic [127:0] p);
    m_ptr = bit_idx(st);
    m_hdr = hv ? swap4(h) : '0;
    if (pf && pfx_supported) begin m_pfx = swap4(p); m_pp = 1'b1; end
    else begin m_pfx = '0; m_pp = 1'b0; end
  endtask

  task automatic compare(input string tag);
    chk(tag, "first_ptr", 128'(first_ptr), 128'(m_ptr));
    chk(tag, "unc_status", 128'(unc_status), 128'(m_st));
    chk(tag, "hdr_log", hdr_log, m_hdr);
    chk(tag, "pfx_log", pfx_log, m_pfx);
    chk(tag, "pfx_present", 128'(pfx_present), 128'(m_pp));
    chk(tag, "q_count", 128'(q_count), 128'(m_cnt));
    chk(tag, "ovf_err", 128'(ovf_err), 128'(m_ovf));
  endtask

  task automatic step(input logic rv, input logic [31:0] st, input logic hv,
                      input logic pf, input logic [127:0] h, input logic [127:0] p,
                      input logic cv, input logic [31:0] mask, input string tag);
    logic [31:0] after;
    rec_valid = rv; rec_status = st; rec_hdr_valid = hv; rec_pfx_flag = pf;
    rec_hdr = h; rec_pfx = p; clr_valid = cv; clr_mask = mask;
    #1;
    chk(cv ? "R11" : tag, "rec_ready", 128'(rec_ready), 128'(!cv));
    m_ovf = 1'b0;
    if (rv && !cv && $countones(st) == 1) begin
      if (multi_en && m_st[m_ptr]) begin
        if (m_cnt < DEPTH) begin
          q_st[m_cnt] = st; q_hv[m_cnt] = hv; q_pf[m_cnt] = pf;
          q_hdr[m_cnt] = h; q_pfx[m_cnt] = p; m_cnt++;
        end else m_ovf = 1'b1;
      end else m_load(st, hv, pf, h, p);
      m_st = m_st | st;
    end else if (cv) begin
      after = m_st & ~mask;
      if (!after[m_ptr]) begin
        if (multi_en && m_cnt > 0) begin
          for (int k = 0; k < m_cnt; k++) after = after | q_st[k];
          m_load(q_st[0], q_hv[0], q_pf[0], q_hdr[0], q_pfx[0]);
          for (int k = 0; k < DEPTH - 1; k++) begin
            q_st[k] = q_st[k+1]; q_hv[k] = q_hv[k+1]; q_pf[k] = q_pf[k+1];
            q_hdr[k] = q_hdr[k+1]; q_pfx[k] = q_pfx[k+1];
          end
          m_cnt--;
        end else begin
          m_ptr = '0; m_hdr = '0; m_pfx = '0; m_pp = 1'b0;
        end
      end else if (multi_en) begin
        for (int k = 0; k < m_cnt; k++) after = after | q_st[k];
      end else m_cnt = 0;
      m_st = after;
    end
    @(posedge clk); @(negedge clk);
    compare(tag);
    rec_valid = 1'b0; clr_valid = 1'b0;
  endtask

  localparam logic [127:0] H1 = 128'h00112233_44556677_8899aabb_ccddeeff;
  localparam logic [127:0] P1 = 128'hdeadbeef_01020304_a0b0c0d0_11223344;

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    m_st = '0; m_ptr = '0; m_hdr = '0; m_pfx = '0; m_pp = 1'b0; m_ovf = 1'b0; m_cnt = 0;
    repeat (3) @(negedge clk);
    compare("R2");
    rst_n = 1'b1; multi_en = 1'b1; pfx_supported = 1'b1;
    @(negedge clk);
    compare("R2");
    chk("R10", "capable", 128'(multi_capable), 128'(1));
    chk("R10", "active", 128'(multi_active), 128'(1));
    chk("R10", "capable0", 128'(z_cap), 128'(0));
    chk("R10", "active0", 128'(z_act), 128'(0));

    step(1, 32'h2, 1, 1, H1, P1, 0, 0, "R5");
    step(1, 32'h8, 1, 0, ~H1, P1, 0, 0, "R3");
    chk("R10", "ptr_depth0", 128'(z_ptr), 128'(3));
    step(1, 32'h20, 0, 1, H1 ^ P1, ~P1, 0, 0, "R3");
    step(1, 32'h80, 1, 1, P1, H1, 0, 0, "R3");
    step(1, 32'h100, 1, 0, H1, H1, 0, 0, "R3");
    step(1, 32'h200, 1, 1, P1, P1, 0, 0, "R4");
    step(0, 0, 0, 0, 0, 0, 0, 0, "R4");
    step(0, 0, 0, 0, 0, 0, 1, 32'h20, "R9");
    step(0, 0, 0, 0, 0, 0, 1, 32'h0a, "R7");
    step(0, 0, 0, 0, 0, 0, 1, 32'h08, "R7");
    multi_en = 1'b0;
    #1 chk("R10", "active_off", 128'(multi_active), 128'(0));
    step(0, 0, 0, 0, 0, 0, 1, 32'h0, "R9");
    step(0, 0, 0, 0, 0, 0, 1, bit_idx(0) == 0 ? (32'h1 << m_ptr) : 0, "R8");
    step(1, 32'h6, 1, 1, H1, P1, 0, 0, "R1");
    step(1, 32'h0, 1, 1, H1, P1, 0, 0, "R1");
    pfx_supported = 1'b0;
    step(1, 32'h4, 0, 1, H1, P1, 0, 0, "R6");
    step(1, 32'h40, 1, 1, H1, P1, 1, 32'h0, "R11");

    multi_en = 1'b1; pfx_supported = 1'b1;
    for (int i = 0; i < 3000; i++) begin
      int r;
      logic [31:0] st, mask;
      r = $urandom % 10;
      if (r < 5) begin
        st = 32'h1 << ($urandom % 8);
        if ($urandom % 10 == 0) st = $urandom % 256;
        step(1, st, 1'($urandom), 1'($urandom),
             {$urandom, $urandom, $urandom, $urandom},
             {$urandom, $urandom, $urandom, $urandom},
             1'($urandom % 8 == 0), 32'h0, "R12");
      end else if (r < 9) begin
        mask = $urandom % 256;
        if ($urandom % 2) mask = mask | (32'h1 << m_ptr);
        step(0, 0, 0, 0, 0, 0, 1, mask, "R12");
      end else begin
        if ($urandom % 3 == 0) multi_en = ~multi_en;
        pfx_supported = 1'($urandom);
        step(0, 0, 0, 0, 0, 0, 0, 0, "R12");
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule